// File: doc/BRIEF.md
# Full-Duplex SPI Slave Packet Port

This block is the host-facing serial port of a receiver signal-processing chip. The host microcontroller acts as SPI master and trades fixed 32-bit packets with the chip. A packet is an 8-bit identifier followed by a 24-bit payload, and it travels most significant bit first. The exchange is full duplex. While the host clocks a command packet in, the block clocks a real outbound packet out, so both directions carry valid data.

The serial clock, data-in and select lines are brought into the system clock domain through two-flop synchronisers, and their edges are found there. The system clock must run at least four times faster than the serial clock. The host must allow four system clocks between lowering select and the first rising serial clock edge. When a frame completes, the core receives a one-cycle strobe with the identifier and the payload. On the core side, a load port fills a single holding register that is sampled when select falls. The core sees whether that register is free through a ready flag.

Top module: `spi_pkt_slave`

## Requirements
- R1: Right after reset, rx_valid is 0, tx_ready is 1, miso is 0 and miso_oe is 0.
- R2: Serial data is sampled on the rising sck edge (SPI mode 0), most significant bit first. After exactly 32 rising edges within one select, rx_valid pulses for a single cycle. At that pulse, rx_id holds the first 8 bits received and rx_payload holds the following 24 bits.
- R3: If cs_n rises before the 32nd rising edge, the frame produces no strobe. The next frame is assembled from its own first bit.
- R4: Rising edges after the 32nd one within the same select are ignored. The frame gives one strobe, and that strobe carries the first 32 bits.
- R5: When select falls, a pending outbound packet is copied to the output shifter. It leaves on miso, identifier first and most significant bit first. miso changes only after falling sck edges, so each bit is stable at the host's rising edge.
- R6: If no packet is pending when select falls, the frame sends 32 zero bits.
- R7: tx_load makes tx_ready 0 from the next cycle until a frame start takes the packet. A load made during a frame does not change the bits of that frame and is sent in the next frame.
- R8: While select is deasserted, miso_oe is 0 and miso is 0.
- R9: If tx_load coincides with the cycle in which the block detects the select fall, the frame sends the packet held before that load, or zeros if none was held. The newly loaded packet stays pending for the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low select from the host |
| miso | output | 1 | Serial data to the host, 0 when idle |
| miso_oe | output | 1 | Drive enable for an external miso buffer |
| rx_valid | output | 1 | One-cycle strobe for a received packet |
| rx_id | output | 8 | Identifier of the received packet |
| rx_payload | output | 24 | Payload of the received packet |
| tx_load | input | 1 | Writes tx_id/tx_payload into the holding register |
| tx_id | input | 8 | Identifier of the outbound packet |
| tx_payload | input | 24 | Payload of the outbound packet |
| tx_ready | output | 1 | Holding register is free |

## Verification
Two functions can fall in the same system cycle. One is the frame start, which takes the holding register into the shifter. The other is a core load, which writes that same register. The bench provokes this by pulsing tx_load on the exact cycle in which the synchronised select fall becomes visible, which is two clock edges after cs_n is driven low. It does this once with a packet already pending and once with the register empty. The bench's behavioural model then expects the older content (or zeros) on miso in that frame and the new packet in the next frame, and it compares both frames bit by bit.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;
  // default packet geometry
  localparam int PKT_ID_W  = 8;
  localparam int PKT_PAY_W = 24;

  // receive framing state within one select
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_DONE  = 2'd2
  } frame_st_e;
endpackage

// File: rtl/spi_pkt_sync.sv
module spi_pkt_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d_in;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/spi_pkt_frame.sv
module spi_pkt_frame
  import spi_pkt_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck_s,
  input  logic               mosi_s,
  input  logic               cs_n_s,
  output logic               sck_fall,
  output logic               frame_start,
  output logic               frame_active,
  output logic               word_valid,
  output logic [FRAME_W-1:0] word
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  frame_st_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic             sck_d, cs_d;
  logic             sck_rise;

  assign frame_active = ~cs_n_s;
  assign sck_rise     = sck_s & ~sck_d;
  assign sck_fall     = ~sck_s & sck_d & frame_active;
  assign frame_start  = ~cs_n_s & cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= FR_IDLE;
      cnt_q      <= '0;
      sr_q       <= '0;
      sck_d      <= 1'b0;
      cs_d       <= 1'b1;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      sck_d      <= sck_s;
      cs_d       <= cs_n_s;
      word_valid <= 1'b0;
      if (cs_n_s) begin
        st_q  <= FR_IDLE;
        cnt_q <= '0;
      end else if (st_q != FR_DONE && sck_rise) begin
        sr_q <= {sr_q[FRAME_W-2:0], mosi_s};
        if (cnt_q == LAST_BIT) begin
          word       <= {sr_q[FRAME_W-2:0], mosi_s};
          word_valid <= 1'b1;
          st_q       <= FR_DONE;
          cnt_q      <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          st_q  <= FR_SHIFT;
        end
      end
    end
  end

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  // R3
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(frame_active));

  // R4
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == FR_DONE) |-> !word_valid || $past(st_q) != FR_DONE);
endmodule

// File: rtl/spi_pkt_tx.sv
module spi_pkt_tx #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               frame_start,
  input  logic               frame_active,
  input  logic               sck_fall,
  output logic               tx_ready,
  output logic               miso,
  output logic               miso_oe
);
  logic [FRAME_W-1:0] hold_q;
  logic               pend_q;
  logic [FRAME_W-1:0] sr_q;
  logic               oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      sr_q   <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (load) begin
        hold_q <= load_word;
        pend_q <= 1'b1;
      end else if (frame_start) begin
        pend_q <= 1'b0;
      end
      oe_q <= frame_active;
      if (!frame_active)    sr_q <= '0;
      else if (frame_start) sr_q <= pend_q ? hold_q : '0;
      else if (sck_fall)    sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign miso     = sr_q[FRAME_W-1];
  assign miso_oe  = oe_q;
  assign tx_ready = ~pend_q;

  // R7
  load_busy_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !tx_ready);

  // R6
  empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && tx_ready) |=> (sr_q == '0));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !miso_oe |-> !miso);

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_active && !frame_start && !sck_fall && $past(frame_active)) |=> $stable(sr_q));
endmodule

// File: rtl/spi_pkt_slave.sv
module spi_pkt_slave
  import spi_pkt_pkg::*;
#(
  parameter int ID_W        = PKT_ID_W,
  parameter int PAY_W       = PKT_PAY_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck,
  input  logic             mosi,
  input  logic             cs_n,
  output logic             miso,
  output logic             miso_oe,
  output logic             rx_valid,
  output logic [ID_W-1:0]  rx_id,
  output logic [PAY_W-1:0] rx_payload,
  input  logic             tx_load,
  input  logic [ID_W-1:0]  tx_id,
  input  logic [PAY_W-1:0] tx_payload,
  output logic             tx_ready
);
  localparam int FRAME_W = ID_W + PAY_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [2:0]         sync_q;
  logic               sck_fall, frame_start, frame_active;
  logic [FRAME_W-1:0] rx_word;

  spi_pkt_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in ({cs_n, sck, mosi}),
    .d_out(sync_q)
  );

  spi_pkt_frame #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_frame (
    .clk         (clk),
    .rst         (rst),
    .sck_s       (sync_q[1]),
    .mosi_s      (sync_q[0]),
    .cs_n_s      (sync_q[2]),
    .sck_fall    (sck_fall),
    .frame_start (frame_start),
    .frame_active(frame_active),
    .word_valid  (rx_valid),
    .word        (rx_word)
  );

  spi_pkt_tx #(
    .FRAME_W(FRAME_W)
  ) u_tx (
    .clk         (clk),
    .rst         (rst),
    .load        (tx_load),
    .load_word   ({tx_id, tx_payload}),
    .frame_start (frame_start),
    .frame_active(frame_active),
    .sck_fall    (sck_fall),
    .tx_ready    (tx_ready),
    .miso        (miso),
    .miso_oe     (miso_oe)
  );

  assign rx_id      = rx_word[FRAME_W-1 -: ID_W];
  assign rx_payload = rx_word[PAY_W-1:0];

  // R9
  collide_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_load && frame_start) |=> !tx_ready);
endmodule

// File: tb/tb_spi_pkt_slave.sv
module tb_spi_pkt_slave;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic        miso, miso_oe, rx_valid, tx_ready;
  logic [7:0]  rx_id;
  logic [23:0] rx_payload;
  logic        tx_load = 1'b0;
  logic [7:0]  tx_id = '0;
  logic [23:0] tx_payload = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model state
  logic [31:0] rx_q[$];
  logic [31:0] m_hold = '0;
  bit          m_pend = 0;

  always #5 clk = ~clk;

  spi_pkt_slave dut (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .miso_oe(miso_oe), .rx_valid(rx_valid), .rx_id(rx_id),
    .rx_payload(rx_payload), .tx_load(tx_load), .tx_id(tx_id),
    .tx_payload(tx_payload), .tx_ready(tx_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // receive strobe compared against the model on every clock (R2, R3, R4)
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (rx_q.size() == 0) begin
        check(0, "R3 unexpected strobe", {rx_id, rx_payload}, 32'h0);
      end else begin
        logic [31:0] e;
        e = rx_q.pop_front();
        check({rx_id, rx_payload} == e, "R2 received packet", {rx_id, rx_payload}, e);
      end
    end
  end

  task automatic load_pkt(input logic [31:0] w);
    @(negedge clk);
    tx_load = 1'b1; {tx_id, tx_payload} = w;
    @(negedge clk);
    tx_load = 1'b0;
    m_hold = w; m_pend = 1;
    check(tx_ready == 1'b0, "R7 ready low after load", {31'b0, tx_ready}, 32'h0);
  endtask

  // nbits < 32 aborts; collide pulses tx_load on the frame-start cycle; mid_load at bit 10
  task automatic run_frame(input logic [31:0] mo, input int nbits, input bit collide,
                           input bit mid_load, input logic [31:0] extra, input string req);
    logic [31:0] exp_tx, mi;
    mi = '0;
    @(negedge clk);
    cs_n = 1'b0;
    exp_tx = m_pend ? m_hold : 32'h0;
    m_pend = 0;
    if (collide) begin
      @(negedge clk); @(negedge clk);
      tx_load = 1'b1; {tx_id, tx_payload} = extra;
      @(negedge clk);
      tx_load = 1'b0;
      m_hold = extra; m_pend = 1;
    end
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? mo[31-i] : 1'b0;
      if (mid_load && i == 10) begin
        tx_load = 1'b1; {tx_id, tx_payload} = extra;
        @(negedge clk);
        tx_load = 1'b0;
        m_hold = extra; m_pend = 1;
      end
      repeat (HALF) @(negedge clk);
      if (i < 32) mi[31-i] = miso;
      sck = 1'b1;
      if (i == 31) rx_q.push_back(mo);
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    if (nbits >= 32) check(mi == exp_tx, req, mi, exp_tx);
    check(miso == 1'b0 && miso_oe == 1'b0, "R8 idle miso", {30'b0, miso_oe, miso}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rx_valid == 0 && tx_ready == 1 && miso == 0 && miso_oe == 0, "R1 reset state",
          {28'b0, rx_valid, tx_ready, miso, miso_oe}, 32'h4);

    // R6 nothing pending: zeros out, R2 packet in
    run_frame(32'hA512_3456, 32, 0, 0, 0, "R6 empty frame");

    // R5 pending packet leaves identifier first
    load_pkt(32'h3CAB_CDEF);
    run_frame(32'h0102_0304, 32, 0, 0, 0, "R5 outbound packet");
    check(tx_ready == 1'b1, "R7 ready after frame start", {31'b0, tx_ready}, 32'h1);

    // R3 aborted frame, then a clean frame
    load_pkt(32'h7711_2233);
    run_frame(32'hFFFF_FFFF, 12, 0, 0, 0, "R3 abort");
    check(rx_q.size() == 0, "R3 no strobe on abort", rx_q.size(), 32'h0);
    run_frame(32'h5AC3_0F81, 32, 0, 0, 0, "R3 frame after abort");

    // R7 load during a frame is held for the next frame
    load_pkt(32'h1122_3344);
    run_frame(32'hDEAD_BEEF, 32, 0, 1, 32'h99AA_BBCC, "R7 frame untouched by mid load");
    check(tx_ready == 1'b0, "R7 mid load still pending", {31'b0, tx_ready}, 32'h0);
    run_frame(32'h0000_0001, 32, 0, 0, 0, "R7 mid load sent next");

    // R4 extra bits ignored
    run_frame(32'h8000_00FE, 40, 0, 0, 0, "R4 long frame outbound");
    check(rx_q.size() == 0, "R4 single strobe", rx_q.size(), 32'h0);

    // R9 collision with a pending packet, then with an empty register
    load_pkt(32'hC0FF_EE00);
    run_frame(32'h1357_9BDF, 32, 1, 0, 32'h2468_ACE0, "R9 collide keeps old");
    run_frame(32'h0F0F_F0F0, 32, 0, 0, 0, "R9 new packet next frame");
    run_frame(32'h3333_CCCC, 32, 1, 0, 32'hABCD_1234, "R9 collide empty sends zeros");
    run_frame(32'h4444_5555, 32, 0, 0, 0, "R9 new packet after empty collide");

    repeat (10) @(negedge clk);
    check(rx_q.size() == 0, "R2 all strobes seen", rx_q.size(), 32'h0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule